// File: doc/BRIEF.md
# Receive Frame Filter and Status Tagger

This block sits at the tail of an Ethernet receive path and makes one decision per frame. When the end-of-frame strobe arrives, it looks at the conditions that the upstream receive logic has reported for that frame:

- a MAC control frame was detected
- the receive was aborted by an overrun
- a symbol code error occurred
- an alignment error occurred
- the CRC check failed
- the destination address matched none of the filters

It weighs these against three configuration enables: let control frames through, let errored frames through, and copy every frame (promiscuous).

A frame carrying any gated condition is discarded unless that condition's enable is set. A kept frame comes with a six-bit status word for its start-of-packet descriptor, with one flag for each condition present. An overrun-aborted frame is always delivered with its overrun flag, so that software can recover the buffers it had already consumed. Both the verdict and the status word are registered and appear one clock after the strobe.

Top module: `rx_frame_gate`

## Requirements
- R1: For every cycle with `eof_i` high, exactly one of `keep_o` or `drop_o` pulses high in the following cycle. In any cycle not preceded by an `eof_i` cycle, both are low.
- R2: A control frame (`ctrl_frm_i`) is dropped when `pass_ctrl_en_i` is low. When it is kept, status bit 0 is set.
- R3: A frame with `code_err_i` is dropped when `pass_err_en_i` is low. When it is kept, status bit 2 is set.
- R4: A frame with `align_err_i` is dropped when `pass_err_en_i` is low. When it is kept, status bit 3 is set.
- R5: A frame with `crc_err_i` is dropped when `pass_err_en_i` is low. When it is kept, status bit 4 is set.
- R6: A frame with `addr_hit_i` low is dropped when `copy_all_en_i` is low. When it is kept, status bit 5 is set.
- R7: When several conditions are present, every applicable flag is set together. Such a frame is kept only if each condition present has its own enable set.
- R8: A frame with `overrun_i` is always kept. Its status has bit 1 set, plus the flags of every other condition present.
- R9: `status_o` is all zeros in every cycle where `keep_o` is low, including the cycle of a drop.
- R10: The enables are taken only in the `eof_i` cycle. Values they hold in earlier cycles of the frame do not affect the verdict.
- R11: While `rst_n` is low, and in the first cycle after it rises, `keep_o` and `drop_o` are low and `status_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| eof_i | input | 1 | End-of-frame strobe; frame inputs and enables are valid in this cycle |
| ctrl_frm_i | input | 1 | Frame is a MAC control frame |
| overrun_i | input | 1 | Frame was aborted by a receive overrun |
| code_err_i | input | 1 | Frame contained a symbol code error |
| align_err_i | input | 1 | Frame contained an alignment error |
| crc_err_i | input | 1 | Frame failed the CRC check |
| addr_hit_i | input | 1 | Destination address passed at least one match criterion |
| pass_ctrl_en_i | input | 1 | Deliver control frames instead of dropping them |
| pass_err_en_i | input | 1 | Deliver code, alignment and CRC errored frames |
| copy_all_en_i | input | 1 | Promiscuous: deliver frames that missed every address match |
| keep_o | output | 1 | Pulse: frame accepted |
| drop_o | output | 1 | Pulse: frame discarded |
| status_o | output | 6 | Descriptor status flags for a kept frame; zero otherwise |

## Verification
The hardest situation to reach is a frame that carries several conditions at once, where one of them is enabled and another is not, or where an overrun overrides a condition that is disabled. Random frames rarely hit the corners that matter. The stimulus therefore sweeps all 512 combinations of the six frame conditions and the three enables, sending them both as isolated frames and as back-to-back strobes. A further sequence toggles the enables in the cycles before the strobe, to show that only the values present in the strobe cycle take effect.

// File: rtl/rxg_pkg.sv
// Package for the receive frame filter: flag positions in the
// descriptor status word, and which enable gates each condition.
// Assumes the flag order below is fixed, since descriptor software decodes it.
package rxg_pkg;

    localparam int NFLAG     = 6;
    localparam int BIT_CTRL  = 0;
    localparam int BIT_OVR   = 1;
    localparam int BIT_CODE  = 2;
    localparam int BIT_ALIGN = 3;
    localparam int BIT_CRC   = 4;
    localparam int BIT_NOHIT = 5;

    // Which configuration enable, if any, lets a condition pass.
    typedef enum logic [1:0] {
        GATE_NONE = 2'd0,
        GATE_CTRL = 2'd1,
        GATE_ERR  = 2'd2,
        GATE_COPY = 2'd3
    } gate_e;

    // Maps a status-bit position to the enable that governs it.
    function automatic gate_e gate_of(input int idx);
        gate_e g;
        case (idx)
            BIT_CTRL:  g = GATE_CTRL;
            BIT_CODE:  g = GATE_ERR;
            BIT_ALIGN: g = GATE_ERR;
            BIT_CRC:   g = GATE_ERR;
            BIT_NOHIT: g = GATE_COPY;
            default:   g = GATE_NONE;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/rxg_cond_map.sv
// Assembles the per-frame condition vector in status-word bit order.
// Assumes every input is qualified by the end-of-frame strobe elsewhere.
module rxg_cond_map
    import rxg_pkg::*;
#(
    parameter int W = NFLAG
) (
    input  logic         ctrl_frm,
    input  logic         overrun,
    input  logic         code_err,
    input  logic         align_err,
    input  logic         crc_err,
    input  logic         addr_hit,
    output logic [W-1:0] cond
);

    // Place each condition at its status bit; an address miss is active-high.
    always_comb begin
        cond            = '0;
        cond[BIT_CTRL]  = ctrl_frm;
        cond[BIT_OVR]   = overrun;
        cond[BIT_CODE]  = code_err;
        cond[BIT_ALIGN] = align_err;
        cond[BIT_CRC]   = crc_err;
        cond[BIT_NOHIT] = ~addr_hit;
    end

endmodule

// File: rtl/rxg_permit.sv
// Marks each present condition whose enable is clear as blocking the frame.
// Assumes the enables are those present in the end-of-frame cycle.
module rxg_permit
    import rxg_pkg::*;
#(
    parameter int W = NFLAG
) (
    input  logic [W-1:0] cond,
    input  logic         pass_ctrl,
    input  logic         pass_err,
    input  logic         copy_all,
    output logic [W-1:0] blocked
);

    // The enable that governs each bit; an ungated bit never blocks.
    logic [W-1:0] allow;

    for (genvar i = 0; i < W; i++) begin : g_flag
        localparam gate_e GATE = gate_of(i);
        if (GATE == GATE_CTRL) begin : g_ctrl
            assign allow[i] = pass_ctrl;
        end else if (GATE == GATE_ERR) begin : g_err
            assign allow[i] = pass_err;
        end else if (GATE == GATE_COPY) begin : g_copy
            assign allow[i] = copy_all;
        end else begin : g_free
            assign allow[i] = 1'b1;
        end
        // A condition blocks the frame only if it is present and not allowed.
        assign blocked[i] = cond[i] & ~allow[i];
    end

endmodule

// File: rtl/rxg_verdict.sv
// Final keep decision: keep if nothing blocks, or the frame was overrun-aborted.
// Assumes the overrun bit position is given by the package.
module rxg_verdict
    import rxg_pkg::*;
#(
    parameter int W = NFLAG
) (
    input  logic [W-1:0] cond,
    input  logic [W-1:0] blocked,
    output logic         keep
);

    // An overrun forces delivery so that software can reclaim its buffers.
    always_comb begin
        keep = ~(|blocked) | cond[BIT_OVR];
    end

endmodule

// File: rtl/rxg_out_reg.sv
// Registers the verdict and the status word one clock after the strobe.
// Assumes a synchronous active-low reset; the status is cleared unless kept.
module rxg_out_reg #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         eof,
    input  logic         keep_d,
    input  logic [W-1:0] cond,
    output logic         keep_q,
    output logic         drop_q,
    output logic [W-1:0] status_q
);

    // Capture the verdict pulses and the flags of a kept frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            keep_q   <= 1'b0;
            drop_q   <= 1'b0;
            status_q <= '0;
        end else begin
            keep_q   <= eof & keep_d;
            drop_q   <= eof & ~keep_d;
            status_q <= (eof & keep_d) ? cond : '0;
        end
    end

endmodule

// File: rtl/rx_frame_gate.sv
// Top level of the receive frame filter and status tagger. At each end-of-frame
// strobe it decides whether to keep or drop the frame and builds the descriptor status.
// Assumes the frame inputs and enables are valid in the strobe cycle only.
module rx_frame_gate
    import rxg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             eof_i,
    input  logic             ctrl_frm_i,
    input  logic             overrun_i,
    input  logic             code_err_i,
    input  logic             align_err_i,
    input  logic             crc_err_i,
    input  logic             addr_hit_i,
    input  logic             pass_ctrl_en_i,
    input  logic             pass_err_en_i,
    input  logic             copy_all_en_i,
    output logic             keep_o,
    output logic             drop_o,
    output logic [NFLAG-1:0] status_o
);

    logic [NFLAG-1:0] cond;
    logic [NFLAG-1:0] blocked;
    logic             keep_d;

    rxg_cond_map #(.W(NFLAG)) u_map (
        .ctrl_frm  (ctrl_frm_i),
        .overrun   (overrun_i),
        .code_err  (code_err_i),
        .align_err (align_err_i),
        .crc_err   (crc_err_i),
        .addr_hit  (addr_hit_i),
        .cond      (cond)
    );

    rxg_permit #(.W(NFLAG)) u_permit (
        .cond      (cond),
        .pass_ctrl (pass_ctrl_en_i),
        .pass_err  (pass_err_en_i),
        .copy_all  (copy_all_en_i),
        .blocked   (blocked)
    );

    rxg_verdict #(.W(NFLAG)) u_verdict (
        .cond    (cond),
        .blocked (blocked),
        .keep    (keep_d)
    );

    rxg_out_reg #(.W(NFLAG)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .eof      (eof_i),
        .keep_d   (keep_d),
        .cond     (cond),
        .keep_q   (keep_o),
        .drop_q   (drop_o),
        .status_q (status_o)
    );

endmodule

// File: rtl/rxg_checker.sv
// Property checker for rx_frame_gate, relating the registered outputs to
// the inputs seen in the strobe cycle. It is attached with a bind below.
module rxg_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       eof_i,
    input logic       ctrl_frm_i,
    input logic       overrun_i,
    input logic       code_err_i,
    input logic       align_err_i,
    input logic       crc_err_i,
    input logic       addr_hit_i,
    input logic       pass_ctrl_en_i,
    input logic       pass_err_en_i,
    input logic       copy_all_en_i,
    input logic       keep_o,
    input logic       drop_o,
    input logic [5:0] status_o
);

    assert_one_verdict_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((keep_o | drop_o) == $past(eof_i)) && !(keep_o && drop_o));

    assert_ctrl_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(eof_i && ctrl_frm_i && !pass_ctrl_en_i && !overrun_i)) |-> drop_o);

    assert_code_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(eof_i && code_err_i && !pass_err_en_i && !overrun_i)) |-> drop_o);

    assert_align_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && keep_o) |-> (status_o[3] == $past(align_err_i)));

    assert_crc_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && keep_o) |-> (status_o[4] == $past(crc_err_i)));

    assert_nohit_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(eof_i && !addr_hit_i && !copy_all_en_i && !overrun_i)) |-> drop_o);

    assert_overrun_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(eof_i && overrun_i)) |-> (keep_o && status_o[1]));

    assert_status_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !keep_o |-> (status_o == 6'd0));

    assert_reset_quiet_R11: assert property (@(posedge clk)
        !$past(rst_n) |-> (!keep_o && !drop_o && status_o == 6'd0));

endmodule

bind rx_frame_gate rxg_checker u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .eof_i          (eof_i),
    .ctrl_frm_i     (ctrl_frm_i),
    .overrun_i      (overrun_i),
    .code_err_i     (code_err_i),
    .align_err_i    (align_err_i),
    .crc_err_i      (crc_err_i),
    .addr_hit_i     (addr_hit_i),
    .pass_ctrl_en_i (pass_ctrl_en_i),
    .pass_err_en_i  (pass_err_en_i),
    .copy_all_en_i  (copy_all_en_i),
    .keep_o         (keep_o),
    .drop_o         (drop_o),
    .status_o       (status_o)
);

// File: tb/sim_rx_frame_gate.sv
// Bench for rx_frame_gate: a behavioural reference model predicts the outputs
// each clock, and a comparator checks them on the falling edge.
module sim_rx_frame_gate;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       eof_i = 1'b0;
    logic       ctrl_frm_i = 1'b0;
    logic       overrun_i = 1'b0;
    logic       code_err_i = 1'b0;
    logic       align_err_i = 1'b0;
    logic       crc_err_i = 1'b0;
    logic       addr_hit_i = 1'b1;
    logic       pass_ctrl_en_i = 1'b0;
    logic       pass_err_en_i = 1'b0;
    logic       copy_all_en_i = 1'b0;
    logic       keep_o;
    logic       drop_o;
    logic [5:0] status_o;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 1'b0;
    bit r10_mode = 1'b0;

    bit         exp_keep = 1'b0;
    bit         exp_drop = 1'b0;
    bit [5:0]   exp_stat = 6'd0;
    string      exp_req = "R11";

    always #5 clk = ~clk;

    rx_frame_gate u0 (
        .clk(clk), .rst_n(rst_n), .eof_i(eof_i), .ctrl_frm_i(ctrl_frm_i),
        .overrun_i(overrun_i), .code_err_i(code_err_i), .align_err_i(align_err_i),
        .crc_err_i(crc_err_i), .addr_hit_i(addr_hit_i),
        .pass_ctrl_en_i(pass_ctrl_en_i), .pass_err_en_i(pass_err_en_i),
        .copy_all_en_i(copy_all_en_i), .keep_o(keep_o), .drop_o(drop_o),
        .status_o(status_o)
    );

    // Reference model: predicts what the outputs show after this edge.
    always @(posedge clk) begin
        bit ok;
        bit [5:0] f;
        int n;
        if (!rst_n) begin
            exp_keep = 0; exp_drop = 0; exp_stat = 0; exp_req = "R11";
        end else if (!eof_i) begin
            exp_keep = 0; exp_drop = 0; exp_stat = 0; exp_req = "R1";
        end else begin
            ok = 1; f = 0; n = 0;
            if (ctrl_frm_i)  begin f = f | 6'd1;  n++; if (!pass_ctrl_en_i) ok = 0; exp_req = "R2"; end
            if (code_err_i)  begin f = f | 6'd4;  n++; if (!pass_err_en_i)  ok = 0; exp_req = "R3"; end
            if (align_err_i) begin f = f | 6'd8;  n++; if (!pass_err_en_i)  ok = 0; exp_req = "R4"; end
            if (crc_err_i)   begin f = f | 6'd16; n++; if (!pass_err_en_i)  ok = 0; exp_req = "R5"; end
            if (!addr_hit_i) begin f = f | 6'd32; n++; if (!copy_all_en_i)  ok = 0; exp_req = "R6"; end
            if (n == 0) exp_req = "R1";
            if (n > 1)  exp_req = "R7";
            if (overrun_i) begin f = f | 6'd2; ok = 1; exp_req = "R8"; end
            if (!ok) exp_req = (n > 1) ? "R7" : exp_req;
            if (r10_mode) exp_req = "R10";
            exp_keep = ok;
            exp_drop = !ok;
            exp_stat = ok ? f : 6'd0;
        end
    end

    // Comparator on the falling edge.
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (keep_o !== exp_keep || drop_o !== exp_drop) begin
                fails++;
                $display("FAIL %s verdict keep/drop actual %b/%b expected %b/%b",
                         exp_req, keep_o, drop_o, exp_keep, exp_drop);
            end
            checks++;
            if (status_o !== exp_stat) begin
                fails++;
                $display("FAIL %s status actual %b expected %b",
                         exp_keep ? exp_req : "R9", status_o, exp_stat);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog R1 actual %0d cycles expected completion", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // Presents one frame's conditions in the strobe cycle.
    task automatic frame(input bit [8:0] v, input bit gap);
        @(posedge clk); #1;
        eof_i = 1;
        ctrl_frm_i = v[0]; overrun_i = v[1]; code_err_i = v[2];
        align_err_i = v[3]; crc_err_i = v[4]; addr_hit_i = ~v[5];
        pass_ctrl_en_i = v[6]; pass_err_en_i = v[7]; copy_all_en_i = v[8];
        if (gap) begin
            @(posedge clk); #1;
            eof_i = 0;
            // Junk on the frame lines while idle must not produce a verdict (R1).
            ctrl_frm_i = ~v[0]; code_err_i = 1; crc_err_i = 1; addr_hit_i = v[5];
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // Frames in isolation over every combination (R2 to R8).
        for (int i = 0; i < 512; i++) frame(9'(i), 1);
        // Back-to-back strobes over every combination (R1, R7).
        for (int i = 0; i < 512; i++) frame(9'(511 - i), 0);
        @(posedge clk); #1 eof_i = 0;
        // R10: the enables open early and close exactly in the strobe cycle.
        for (int k = 0; k < 4; k++) begin
            @(posedge clk); #1;
            eof_i = 0; pass_ctrl_en_i = 1; pass_err_en_i = 1; copy_all_en_i = 1;
            ctrl_frm_i = 1; crc_err_i = 1; addr_hit_i = 0; overrun_i = 0;
            @(posedge clk); #1;
            r10_mode = 1; eof_i = 1;
            pass_ctrl_en_i = k[0]; pass_err_en_i = k[1]; copy_all_en_i = 0;
            @(posedge clk); #1;
            r10_mode = 0; eof_i = 0;
            pass_ctrl_en_i = 0; pass_err_en_i = 0; copy_all_en_i = 0;
        end
        // R10: the enables are closed early and open in the strobe cycle.
        @(posedge clk); #1;
        code_err_i = 1; addr_hit_i = 1; ctrl_frm_i = 0; crc_err_i = 0;
        @(posedge clk); #1;
        r10_mode = 1; eof_i = 1; pass_err_en_i = 1;
        @(posedge clk); #1;
        r10_mode = 0; eof_i = 0; pass_err_en_i = 0;
        // R11: reset again with a strobe pending.
        @(posedge clk); #1;
        rst_n = 0; eof_i = 1; overrun_i = 1;
        @(posedge clk); #1;
        eof_i = 0; overrun_i = 0;
        @(posedge clk); #1 rst_n = 1;
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule